// File: doc/BRIEF.md
# Hotplug Slot Status Register Block

This block keeps the hotplug bookkeeping for a set of selectable buses, each with 32 slots. Platform logic reports slot insertions and removals on two event inputs that carry a bus index and a slot number. The block records them in per-bus pending bitmaps, raises an event status bit and drives an interrupt request toward firmware. Firmware reaches the bitmaps through a small window of 32-bit registers on a simple request/response bus. Every access is redirected through a bus-select register to one bus's state.

Firmware learns of new devices by reading the pending-insert bitmap. That read clears the bitmap, except in legacy mode. Firmware sees requested removals in the pending-remove bitmap and retires them by writing a slot bitmap to the eject register. That write issues one eject pulse for the lowest set slot and drops both of that slot's pending bits. A sweep runs after the hard reset and again on each platform-reset request. It ejects every outstanding removal, bus by bus, and reloads each bus's removable mask from a per-slot "fixed" configuration vector.

Top module: `hp_slot_regs`

## Requirements
- R1: A request takes effect only if `req_be_i` is 4'hF, `req_addr_i[1:0]` is 0 and the offset lies inside the window. Any other request changes nothing and reads as zero. Every request, valid or not, is answered by `rsp_valid_o` exactly one cycle later.
- R2: A read of the pending-insert bitmap at offset 0x00 returns the selected bus's bitmap. In normal mode the bitmap then becomes zero. In legacy mode it is left unchanged.
- R3: A read of the pending-remove bitmap at offset 0x04 does not alter it. The eject offset 0x08 reads as zero. Offsets 0x14 to 0x1C read as zero. The removable mask sits at 0x0C and the bus select at 0x10.
- R4: A write to 0x08 with a nonzero bitmap picks its lowest set bit. It clears that slot in both pending bitmaps of the selected bus, and one cycle later pulses `eject_valid_o` with that bus and slot. A zero bitmap has no effect.
- R5: When the select value is NUM_BUSES or more, eject writes are ignored and reads of every offset return zero.
- R6: A plug event not flagged as present at boot sets the slot's insert bit. An unplug event sets the slot's remove bit. Each such event sets event status bit 1 (value 0x02). A boot-time plug, or an event naming a bus that does not exist, has no effect.
- R7: `irq_o` is high in the cycle after status bit 1 and enable bit 1 are both set. A write to `evt_wdata_i` with bit 1 set clears the status bit. A new event in the same cycle wins over the clear.
- R8: After the hard reset or a `sweep_req_i` pulse, `sweep_busy_o` is high. The sweep walks the buses in ascending order and ejects each pending removal lowest slot first, one per cycle, with a pulse. It then loads the bus's removable mask as the inverse of its bits in `fixed_slots_i`. With nothing pending, the sweep lasts NUM_BUSES cycles.
- R9: While a sweep is running, reads return zero and writes are ignored.
- R10: In legacy mode only bus 0 exists. Offset 0x10 reads zero and ignores writes, and events for other buses are ignored.
- R11: In normal mode a write to 0x10 sets the select value, and a read of 0x10 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| legacy_i | input | 1 | Legacy mode: single bus, no select register, non-clearing reads |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset in the window |
| req_wdata_i | input | 32 | Write data, little-endian |
| req_be_i | input | 4 | Byte enables; only 4'hF is valid |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |
| plug_valid_i | input | 1 | Insertion event strobe |
| plug_boot_i | input | 1 | Insertion belongs to a device present at boot |
| plug_bus_i | input | 8 | Insertion bus index |
| plug_slot_i | input | 5 | Insertion slot number |
| unplug_valid_i | input | 1 | Removal request strobe |
| unplug_bus_i | input | 8 | Removal bus index |
| unplug_slot_i | input | 5 | Removal slot number |
| fixed_slots_i | input | 256 | Per bus, per slot: 1 = not hotpluggable (bus b at bits 32b+31..32b) |
| sweep_req_i | input | 1 | Platform-reset pulse that starts a sweep |
| sweep_busy_o | output | 1 | Sweep in progress |
| eject_valid_o | output | 1 | Eject pulse |
| eject_bus_o | output | 3 | Bus of the ejected slot |
| eject_slot_o | output | 5 | Ejected slot |
| evt_en_i | input | 8 | Event enable bits |
| evt_wr_i | input | 1 | Event status write-1-to-clear strobe |
| evt_wdata_i | input | 8 | Event status bits to clear |
| evt_sts_o | output | 8 | Event status (bit 1 used) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the sweep with removals pending on several buses at once. The bench first leaves unejected removals on three buses, one of them holding two slots and one also holding an insert bit for the same slot. It then pulses the platform reset. The scoreboard has the eject order queued in advance: ascending bus, lowest slot first. A read and a select write are issued while the sweep is still running, so both the ordering and the blocking of register access during the sweep are observed.

// File: rtl/hp_regs_pkg.sv
package hp_regs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EVT_W  = 8;
  localparam logic [EVT_W-1:0] EVT_MASK = 8'h02;

  // register word indices inside the window (offset >> 2)
  localparam logic [2:0] IX_UP  = 3'd0;
  localparam logic [2:0] IX_DN  = 3'd1;
  localparam logic [2:0] IX_EJ  = 3'd2;
  localparam logic [2:0] IX_RMV = 3'd3;
  localparam logic [2:0] IX_SEL = 3'd4;

  // index of the lowest set bit; zero when none is set
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_bus_bank.sv
module hp_bus_bank #(
  parameter int unsigned S = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [S-1:0] set_up_i,
  input  logic [S-1:0] set_dn_i,
  input  logic [S-1:0] clr_i,
  input  logic         wipe_up_i,
  input  logic         load_rmv_i,
  input  logic [S-1:0] rmv_val_i,
  output logic [S-1:0] up_o,
  output logic [S-1:0] dn_o,
  output logic [S-1:0] rmv_o
);
  logic [S-1:0] up_q, dn_q, rmv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= '0;
      dn_q  <= '0;
      rmv_q <= '0;
    end else begin
      up_q <= (wipe_up_i ? '0 : (up_q & ~clr_i)) | set_up_i;
      dn_q <= (dn_q & ~clr_i) | set_dn_i;
      if (load_rmv_i) rmv_q <= rmv_val_i;
    end
  end

  assign up_o  = up_q;
  assign dn_o  = dn_q;
  assign rmv_o = rmv_q;

  // R4: an eject names a single slot
  a_r4_clr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_i));
  // R4: a retired slot leaves the remove bitmap unless re-requested
  a_r4_clear_sticks: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_dn_i)) |=> ((dn_q & $past(clr_i & ~set_dn_i)) == '0));
  // R6: a removal request is recorded
  a_r6_dn_recorded: assert property (@(posedge clk) disable iff (rst)
    (|set_dn_i) |=> ((dn_q & $past(set_dn_i)) == $past(set_dn_i)));
endmodule

// File: rtl/hp_host_if.sv
module hp_host_if
  import hp_regs_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned S  = 32,
  parameter int unsigned BW = 3,
  parameter int unsigned SW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_i,
  input  logic              busy_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [4:0]        req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [3:0]        req_be_i,
  input  logic [S-1:0]      up_sel_i,
  input  logic [S-1:0]      dn_sel_i,
  input  logic [S-1:0]      rmv_sel_i,
  output logic              sel_ok_o,
  output logic [BW-1:0]     sel_idx_o,
  output logic              rd_up_o,
  output logic              wr_ej_o,
  output logic [SW-1:0]     ej_slot_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o
);
  localparam logic [WORD_W-1:0] NB_W = WORD_W'(NB);

  logic [WORD_W-1:0] sel_q, eff_sel, rdata_d;
  logic [2:0]        idx;
  logic              fmt_ok, in_win, acc, rd_acc;
  logic [4:0]        ej_pos;

  assign idx     = req_addr_i[4:2];
  assign fmt_ok  = req_valid_i && !busy_i && (req_be_i == 4'hF) && (req_addr_i[1:0] == 2'b00);
  assign in_win  = legacy_i ? (idx <= IX_RMV) : (idx <= IX_SEL);
  assign acc     = fmt_ok && in_win;
  assign rd_acc  = acc && !req_write_i;
  assign eff_sel = legacy_i ? '0 : sel_q;

  assign sel_ok_o  = eff_sel < NB_W;
  assign sel_idx_o = eff_sel[BW-1:0];
  assign rd_up_o   = rd_acc && (idx == IX_UP) && sel_ok_o;
  assign wr_ej_o   = acc && req_write_i && (idx == IX_EJ) && sel_ok_o &&
                     (req_wdata_i[S-1:0] != '0);
  assign ej_pos    = lowest_set(WORD_W'(req_wdata_i[S-1:0]));
  assign ej_slot_o = ej_pos[SW-1:0];

  always_comb begin
    rdata_d = '0;
    if (rd_acc && sel_ok_o) begin
      case (idx)
        IX_UP:   rdata_d = WORD_W'(up_sel_i);
        IX_DN:   rdata_d = WORD_W'(dn_sel_i);
        IX_RMV:  rdata_d = WORD_W'(rmv_sel_i);
        IX_SEL:  rdata_d = sel_q;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= rdata_d;
      if (acc && req_write_i && (idx == IX_SEL)) sel_q <= req_wdata_i;
    end
  end

  // R1: every request is answered in the next cycle
  a_r1_rsp_every_req: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> rsp_valid_o);
  // R10: the select value cannot move in legacy mode
  a_r10_legacy_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    legacy_i |=> $stable(sel_q));
  // R9: no register write lands during a sweep
  a_r9_sel_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(sel_q));
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep
  import hp_regs_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned S  = 32,
  parameter int unsigned BW = 3,
  parameter int unsigned SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [S-1:0]  dn_cur_i,
  output logic          busy_o,
  output logic [BW-1:0] bus_o,
  output logic          ej_v_o,
  output logic [SW-1:0] ej_slot_o,
  output logic          load_o
);
  localparam logic [BW-1:0] LAST = BW'(NB - 1);

  logic [4:0] pos;
  logic       idle_bus;

  assign idle_bus  = (dn_cur_i == '0);
  assign pos       = lowest_set(WORD_W'(dn_cur_i));
  assign ej_v_o    = busy_o && !idle_bus;
  assign ej_slot_o = pos[SW-1:0];
  assign load_o    = busy_o && idle_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b1;
      bus_o  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        bus_o  <= '0;
      end
    end else if (idle_bus) begin
      if (bus_o == LAST) busy_o <= 1'b0;
      else bus_o <= bus_o + 1'b1;
    end
  end

  // R8: buses are visited in ascending order
  a_r8_bus_ascending: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> (bus_o >= $past(bus_o)));
  // R8: a bus is left only when its removals are drained
  a_r8_drain_before_step: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !idle_bus) |=> (busy_o && $stable(bus_o)));
endmodule

// File: rtl/hp_evt.sv
module hp_evt
  import hp_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             wr_i,
  input  logic [EVT_W-1:0] wdata_i,
  input  logic [EVT_W-1:0] en_i,
  output logic [EVT_W-1:0] sts_o,
  output logic             irq_o
);
  logic sts_q, sts_d, clr_hit;

  assign clr_hit = wr_i && ((wdata_i & EVT_MASK) != '0);
  assign sts_d   = set_i | (sts_q & ~clr_hit);
  assign sts_o   = sts_q ? EVT_MASK : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_o <= |((sts_d ? EVT_MASK : '0) & en_i);
    end
  end

  // R6: an event always leaves the status bit set
  a_r6_event_sets_status: assert property (@(posedge clk) disable iff (rst)
    set_i |=> sts_q);
  // R7: no interrupt without the status bit
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> sts_q);
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_regs_pkg::*;
#(
  parameter int unsigned NB    = 8,
  parameter int unsigned S     = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned BW    = (NB > 1) ? $clog2(NB) : 1,
  parameter int unsigned SW    = (S > 1) ? $clog2(S) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [4:0]        req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [3:0]        req_be_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  input  logic              plug_valid_i,
  input  logic              plug_boot_i,
  input  logic [IDX_W-1:0]  plug_bus_i,
  input  logic [SW-1:0]     plug_slot_i,
  input  logic              unplug_valid_i,
  input  logic [IDX_W-1:0]  unplug_bus_i,
  input  logic [SW-1:0]     unplug_slot_i,
  input  logic [NB*S-1:0]   fixed_slots_i,
  input  logic              sweep_req_i,
  output logic              sweep_busy_o,
  output logic              eject_valid_o,
  output logic [BW-1:0]     eject_bus_o,
  output logic [SW-1:0]     eject_slot_o,
  input  logic [EVT_W-1:0]  evt_en_i,
  input  logic              evt_wr_i,
  input  logic [EVT_W-1:0]  evt_wdata_i,
  output logic [EVT_W-1:0]  evt_sts_o,
  output logic              irq_o
);
  localparam logic [IDX_W-1:0] NB_I = IDX_W'(NB);
  localparam logic [S-1:0]     ONE  = S'(1);

  logic [S-1:0] up_a [NB];
  logic [S-1:0] dn_a [NB];
  logic [S-1:0] rmv_a [NB];

  logic          sel_ok, rd_up, wr_ej, busy, sw_ej_v, sw_load;
  logic [BW-1:0] sel_idx, sw_bus, ej_bus;
  logic [SW-1:0] host_slot, sw_slot, ej_slot;
  logic          ej_v, plug_hit, unplug_hit;

  assign plug_hit   = plug_valid_i && !plug_boot_i && (plug_bus_i < NB_I) &&
                      (!legacy_i || (plug_bus_i == '0));
  assign unplug_hit = unplug_valid_i && (unplug_bus_i < NB_I) &&
                      (!legacy_i || (unplug_bus_i == '0));

  // sweep ejects and host ejects never coincide: host access is blocked while busy
  assign ej_v    = sw_ej_v | wr_ej;
  assign ej_bus  = busy ? sw_bus : sel_idx;
  assign ej_slot = busy ? sw_slot : host_slot;

  hp_host_if #(.NB(NB), .S(S), .BW(BW), .SW(SW)) u_host (
    .clk(clk), .rst(rst), .legacy_i(legacy_i), .busy_i(busy),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .up_sel_i(up_a[sel_idx]), .dn_sel_i(dn_a[sel_idx]), .rmv_sel_i(rmv_a[sel_idx]),
    .sel_ok_o(sel_ok), .sel_idx_o(sel_idx), .rd_up_o(rd_up), .wr_ej_o(wr_ej),
    .ej_slot_o(host_slot), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  hp_sweep #(.NB(NB), .S(S), .BW(BW), .SW(SW)) u_sweep (
    .clk(clk), .rst(rst), .start_i(sweep_req_i), .dn_cur_i(dn_a[sw_bus]),
    .busy_o(busy), .bus_o(sw_bus), .ej_v_o(sw_ej_v), .ej_slot_o(sw_slot),
    .load_o(sw_load)
  );

  hp_evt u_evt (
    .clk(clk), .rst(rst), .set_i(plug_hit | unplug_hit), .wr_i(evt_wr_i),
    .wdata_i(evt_wdata_i), .en_i(evt_en_i), .sts_o(evt_sts_o), .irq_o(irq_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bus
    localparam logic [IDX_W-1:0] BI = IDX_W'(b);
    localparam logic [BW-1:0]    BB = BW'(b);
    logic [S-1:0] set_up, set_dn, clr;
    logic         wipe, load;

    assign set_up = (plug_hit && plug_bus_i == BI) ? (ONE << plug_slot_i) : '0;
    assign set_dn = (unplug_hit && unplug_bus_i == BI) ? (ONE << unplug_slot_i) : '0;
    assign clr    = (ej_v && ej_bus == BB) ? (ONE << ej_slot) : '0;
    assign wipe   = rd_up && !legacy_i && (sel_idx == BB);
    assign load   = sw_load && (sw_bus == BB);

    hp_bus_bank #(.S(S)) u_bank (
      .clk(clk), .rst(rst), .set_up_i(set_up), .set_dn_i(set_dn), .clr_i(clr),
      .wipe_up_i(wipe), .load_rmv_i(load), .rmv_val_i(~fixed_slots_i[b*S +: S]),
      .up_o(up_a[b]), .dn_o(dn_a[b]), .rmv_o(rmv_a[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eject_valid_o <= 1'b0;
      eject_bus_o   <= '0;
      eject_slot_o  <= '0;
    end else begin
      eject_valid_o <= ej_v;
      if (ej_v) begin
        eject_bus_o  <= ej_bus;
        eject_slot_o <= ej_slot;
      end
    end
  end

  assign sweep_busy_o = busy;

  // R9: reads during a sweep return zero
  a_r9_busy_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_write_i && busy) |=> (rsp_rdata_o == '0));
  // R5: an out-of-range select never produces an eject
  a_r5_no_eject_bad_sel: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sel_ok) |=> !eject_valid_o);
endmodule

// File: tb/hp_slot_regs_tb_top.sv
module hp_slot_regs_tb_top;
  localparam int CLK_NS = 10;

  typedef struct {
    bit          chk;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        legacy = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = 4'hF;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        plug_valid = 1'b0, plug_boot = 1'b0, unplug_valid = 1'b0;
  logic [7:0]  plug_bus = '0, unplug_bus = '0;
  logic [4:0]  plug_slot = '0, unplug_slot = '0;
  logic [255:0] fixed_slots;
  logic        sweep_req = 1'b0, busy;
  logic        eject_valid;
  logic [2:0]  eject_bus;
  logic [4:0]  eject_slot;
  logic [7:0]  evt_en = '0, evt_wdata = '0, evt_sts;
  logic        evt_wr = 1'b0, irq;

  int checks = 0, errors = 0;
  rd_item_t rdq[$];
  logic [7:0] ejq[$];
  rd_item_t cur;
  logic [7:0] ej_exp;
  logic [31:0] mup[8], mdn[8];
  int selm = 0;

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    for (int b = 0; b < 8; b++) fixed_slots[b*32 +: 32] = 32'h1 << b;
  end

  hp_slot_regs dut_i (
    .clk(clk), .rst(rst), .legacy_i(legacy),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .plug_valid_i(plug_valid), .plug_boot_i(plug_boot), .plug_bus_i(plug_bus),
    .plug_slot_i(plug_slot), .unplug_valid_i(unplug_valid), .unplug_bus_i(unplug_bus),
    .unplug_slot_i(unplug_slot), .fixed_slots_i(fixed_slots), .sweep_req_i(sweep_req),
    .sweep_busy_o(busy), .eject_valid_o(eject_valid), .eject_bus_o(eject_bus),
    .eject_slot_o(eject_slot), .evt_en_i(evt_en), .evt_wr_i(evt_wr),
    .evt_wdata_i(evt_wdata), .evt_sts_o(evt_sts), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int low_bit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  // scoreboard monitor: responses and eject pulses
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (rdq.size() == 0) chk(1'b0, "R1 unexpected response", rsp_rdata, 32'h0);
      else begin
        cur = rdq.pop_front();
        if (cur.chk) chk(rsp_rdata == cur.exp, cur.tag, rsp_rdata, cur.exp);
      end
    end
    if (eject_valid) begin
      if (ejq.size() == 0) chk(1'b0, "R4 unexpected eject", {24'h0, eject_bus, eject_slot}, 32'h0);
      else begin
        ej_exp = ejq.pop_front();
        chk({eject_bus, eject_slot} == ej_exp, "R4/R8 eject bus/slot",
            {24'h0, eject_bus, eject_slot}, {24'h0, ej_exp});
      end
    end
  end

  task automatic acc(input bit wr, input logic [4:0] a, input logic [31:0] d,
                     input logic [3:0] be, input bit c, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.chk = c; it.exp = exp; it.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    rdq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    acc(1'b0, a, 32'h0, 4'hF, 1'b1, exp, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    acc(1'b1, a, d, 4'hF, 1'b0, 32'h0, "");
  endtask

  task automatic set_sel(input int v);
    wr(5'h10, 32'(v));
    if (!legacy) selm = v;
  endtask

  task automatic rd_up(input string tag);
    int s;
    s = legacy ? 0 : selm;
    rd(5'h00, mup[s], tag);
    if (!legacy) mup[s] = '0;
  endtask

  task automatic rd_dn(input string tag);
    rd(5'h04, mdn[legacy ? 0 : selm], tag);
  endtask

  task automatic plug(input int bus, input int slot, input bit boot);
    @(negedge clk);
    plug_valid = 1'b1; plug_bus = 8'(bus); plug_slot = 5'(slot); plug_boot = boot;
    @(negedge clk);
    plug_valid = 1'b0; plug_boot = 1'b0;
    if (!boot && bus < 8 && (!legacy || bus == 0)) mup[bus][slot] = 1'b1;
  endtask

  task automatic unplug(input int bus, input int slot);
    @(negedge clk);
    unplug_valid = 1'b1; unplug_bus = 8'(bus); unplug_slot = 5'(slot);
    @(negedge clk);
    unplug_valid = 1'b0;
    if (bus < 8 && (!legacy || bus == 0)) mdn[bus][slot] = 1'b1;
  endtask

  task automatic eject(input logic [31:0] d);
    int s, k;
    s = legacy ? 0 : selm;
    if (s < 8 && d != 0) begin
      k = low_bit(d);
      ejq.push_back({3'(s), 5'(k)});
      mup[s][k] = 1'b0; mdn[s][k] = 1'b0;
    end
    wr(5'h08, d);
  endtask

  task automatic evt_clear();
    @(negedge clk); evt_wr = 1'b1; evt_wdata = 8'h02;
    @(negedge clk); evt_wr = 1'b0; evt_wdata = 8'h00;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic hard_reset(input bit leg);
    int n;
    @(negedge clk); rst = 1'b1; legacy = leg;
    repeat (3) @(negedge clk);
    for (int b = 0; b < 8; b++) begin mup[b] = '0; mdn[b] = '0; end
    selm = 0;
    rst = 1'b0;
    chk(busy == 1'b1, "R8 busy right after reset", {31'h0, busy}, 32'h1);
    chk({irq, evt_sts} == 9'h0, "R7 irq and status clear after reset", {23'h0, irq, evt_sts}, 32'h0);
    chk(eject_valid == 1'b0, "R4 no eject in reset", {31'h0, eject_valid}, 32'h0);
    wait_idle(n);
    chk(n == 8, "R8 empty sweep lasts NUM_BUSES cycles", 32'(n), 32'd8);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    hard_reset(1'b0);

    // removable mask and select readback
    set_sel(2);
    rd(5'h0C, ~(32'h1 << 2), "R8 removable mask of bus 2");
    rd(5'h10, 32'd2, "R11 select readback");

    // plug event, status, irq, clear-on-read
    evt_en = 8'h02;
    plug(2, 5, 1'b0);
    chk(evt_sts == 8'h02, "R6 plug sets status bit 1", {24'h0, evt_sts}, 32'h2);
    chk(irq == 1'b1, "R7 irq with status and enable", {31'h0, irq}, 32'h1);
    rd_up("R2 insert bitmap read");
    rd_up("R2 insert bitmap cleared by read");
    evt_clear();
    chk({irq, evt_sts} == 9'h0, "R7 write-1-clear drops status and irq", {23'h0, irq, evt_sts}, 32'h0);

    // enable gating
    evt_en = 8'h00;
    unplug(2, 7);
    chk(evt_sts == 8'h02 && irq == 1'b0, "R7 no irq while disabled", {23'h0, irq, evt_sts}, 32'h2);
    evt_en = 8'h02;
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq follows enable", {31'h0, irq}, 32'h1);
    evt_clear();

    // boot-time plug ignored
    plug(2, 9, 1'b1);
    chk(evt_sts == 8'h00, "R6 boot plug raises no event", {24'h0, evt_sts}, 32'h0);
    rd_up("R6 boot plug leaves insert bitmap empty");

    // down bitmap, eject write
    unplug(2, 5);
    plug(2, 5, 1'b0);
    rd_dn("R3 remove bitmap read");
    rd_dn("R3 remove bitmap read is non-destructive");
    rd(5'h08, 32'h0, "R3 eject offset reads zero");
    rd(5'h14, 32'h0, "R3 offset past window reads zero");
    eject(32'h0000_00A0);
    rd_dn("R4 eject clears lowest slot from remove bitmap");
    rd_up("R4 eject clears same slot from insert bitmap");
    eject(32'h0);

    // out of range select
    set_sel(9);
    rd(5'h04, 32'h0, "R5 read with bad select is zero");
    rd(5'h10, 32'h0, "R5 select read with bad select is zero");
    wr(5'h08, 32'h80);
    set_sel(2);
    rd_dn("R5 eject ignored with bad select");

    // malformed accesses
    acc(1'b1, 5'h10, 32'd3, 4'h3, 1'b0, 32'h0, "");
    rd(5'h10, 32'd2, "R1 partial byte-enable write ignored");
    acc(1'b1, 5'h11, 32'd3, 4'hF, 1'b0, 32'h0, "");
    rd(5'h10, 32'd2, "R1 misaligned write ignored");
    acc(1'b0, 5'h04, 32'h0, 4'h0, 1'b1, 32'h0, "R1 read without byte enables is zero");

    // event on a missing bus
    evt_clear();
    unplug(8, 1);
    chk(evt_sts == 8'h00, "R6 event on missing bus ignored", {24'h0, evt_sts}, 32'h0);

    // sweep with several buses pending (bus 2 still holds slot 7)
    unplug(1, 9);
    unplug(1, 4);
    plug(1, 9, 1'b0);
    unplug(3, 0);
    for (int b = 0; b < 8; b++) begin
      while (mdn[b] != 0) begin
        n = low_bit(mdn[b]);
        ejq.push_back({3'(b), 5'(n)});
        mdn[b][n] = 1'b0; mup[b][n] = 1'b0;
      end
    end
    @(negedge clk); sweep_req = 1'b1;
    @(negedge clk); sweep_req = 1'b0;
    chk(busy == 1'b1, "R8 sweep request starts sweep", {31'h0, busy}, 32'h1);
    rd(5'h10, 32'h0, "R9 read during sweep is zero");
    wr(5'h10, 32'd5);
    wait_idle(n);
    chk(busy == 1'b0, "R8 sweep finishes", {31'h0, busy}, 32'h0);
    rd(5'h10, 32'd2, "R9 write during sweep ignored");
    set_sel(1);
    rd_up("R8 sweep cleared insert bit of ejected slot");
    rd_dn("R8 sweep drained remove bitmap");

    // legacy mode
    hard_reset(1'b1);
    plug(0, 3, 1'b0);
    rd_up("R2 legacy insert read");
    rd_up("R2 legacy insert read does not clear");
    rd(5'h10, 32'h0, "R10 select offset outside legacy window");
    wr(5'h10, 32'd5);
    rd_up("R10 legacy select stays on bus 0");
    evt_clear();
    plug(1, 2, 1'b0);
    chk(evt_sts == 8'h00, "R10 legacy ignores other buses", {24'h0, evt_sts}, 32'h0);
    unplug(0, 6);
    eject(32'h40);
    rd_dn("R4 legacy eject clears remove bit");

    repeat (4) @(negedge clk);
    chk(rdq.size() == 0, "R1 all responses seen", 32'(rdq.size()), 32'h0);
    chk(ejq.size() == 0, "R8 all expected ejects seen", 32'(ejq.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule